// File: doc/BRIEF.md
# I2C Slave Interface with Clock Stretching

This block sits on a two-wire bus as a target device. It watches the synchronised clock and data lines, spots START and STOP conditions, and shifts in the first byte of each transfer. The upper seven bits of that byte are compared against an own-address input. The all-zero address is taken as a general call. When the block is addressed, it acknowledges and then either takes in data bytes from the master or sends out bytes that software has loaded.

Each event that software must handle raises a pending-service condition. The block then holds SCL low, so the master waits. Software reads the status flags, then reads the data register, writes it, or writes the pend-set strobe. Any of these ends the stretch, but SCL stays low until a programmable floor of system clocks has passed since the hold began.

A companion master engine can report lost arbitration. The block then carries on as a target for the rest of the byte and raises a service request when that byte ends.

Top module: `i2c_slave_stretch`

## Requirements
- R1: After reset, neither bus line is pulled low, `irq_o` is 0, `pend_o` is 1 and all four status flags are 0.
- R2: A first byte whose bits 7:1 (sent MSB first) equal `own_addr_i` is acknowledged by pulling SDA low during the ninth clock. After that clock, `st_aas_o` is 1, `st_trx_o` equals bit 0 of the byte, and `irq_o` rises.
- R3: A first byte that matches neither the own address nor the general call leaves SDA released on the ninth clock and raises no interrupt. Later bytes up to the next START are ignored: no acknowledge and no interrupt.
- R4: A first byte of 0x00 is acknowledged and sets `st_ad0_o` to 1 and `st_aas_o` to 0. After the ninth clock, `irq_o` rises.
- R5: In receive mode, each data byte is shifted in MSB first and acknowledged. It appears on `dat_rdata_o`, and `irq_o` rises after the ninth clock of every byte.
- R6: In transmit mode (`st_trx_o`=1), the byte written through `dat_wr_i` goes out MSB first. If the master acknowledges, `irq_o` rises again. If the master does not acknowledge, SDA stays released, `st_trx_o` clears and no interrupt follows.
- R7: When a service request is raised, `pend_o` drops to 0, `irq_o` goes to 1 and SCL is held low. The hold lasts until `dat_rd_i`, `dat_wr_i` or `pend_set_i` is pulsed.
- R8: SCL is held low for at least `min_low_i` system clocks from the start of a hold, even if the release comes earlier.
- R9: A pulse on `arb_lost_i` sets `st_al_o`. It also raises a service request at the end of the ninth clock of the current byte, whether or not the block is addressed. The next START clears `st_al_o`.
- R10: A STOP clears `st_aas_o` and `st_ad0_o` and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| scl_low_o | output | 1 | 1 pulls the clock line low |
| sda_low_o | output | 1 | 1 pulls the data line low |
| own_addr_i | input | ADDR_W | Own target address |
| min_low_i | input | LOW_CNT_W | Minimum hold length in system clocks |
| dat_wr_i | input | 1 | Data register write strobe (also releases) |
| dat_wdata_i | input | DATA_W | Byte to transmit |
| dat_rd_i | input | 1 | Data register read strobe (also releases) |
| dat_rdata_o | output | DATA_W | Last received byte |
| pend_set_i | input | 1 | Write-one strobe to the pending bit (releases) |
| arb_lost_i | input | 1 | Arbitration-lost pulse from a master engine |
| irq_o | output | 1 | Service request, high while pending |
| pend_o | output | 1 | Pending bit, 0 while service is pending |
| st_al_o | output | 1 | Arbitration-lost flag |
| st_trx_o | output | 1 | 1 = transmitting to master |
| st_aas_o | output | 1 | Addressed by own address |
| st_ad0_o | output | 1 | Addressed by general call |

## Verification
Arbitration loss and an own-address match can land in the same byte. Both then resolve on the same ninth-clock falling edge, where the addressed-event path and the arbitration-loss path both want to raise a service request. The bench provokes this by pulsing `arb_lost_i` partway through a byte carrying the block's own address. It expects an acknowledge, both `st_al_o` and `st_aas_o` set, and a single pending request that one pend-set pulse clears. A separate case loses arbitration on a foreign address, and there the interrupt must come from the arbitration path alone.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_ADDR,
      S_ADDR_ACK,
      S_RX,
      S_RX_ACK,
      S_TX,
      S_TX_ACK,
      S_SKIP
   } slv_state_t;

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= (chain_q << 1) | STAGES'(d_i);
         end
         assign q_o = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);
   logic scl_s, sda_s, scl_q, sda_q;

   i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s));
   i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign sda_s_o    = sda_s;
   assign scl_rise_o = scl_s & ~scl_q;
   assign scl_fall_o = ~scl_s & scl_q;
   assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cs_stretch.sv
module i2cs_stretch #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             svc_event_i,
   input  logic             release_i,
   input  logic [CNT_W-1:0] min_low_i,
   output logic             pend_o,
   output logic             scl_hold_o
);
   logic             pend_q;
   logic [CNT_W-1:0] floor_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q    <= 1'b1;
         floor_cnt <= '0;
      end else begin
         if (svc_event_i)    pend_q <= 1'b0;
         else if (release_i) pend_q <= 1'b1;

         if (svc_event_i)           floor_cnt <= min_low_i;
         else if (floor_cnt != '0)  floor_cnt <= floor_cnt - CNT_W'(1);
      end
   end

   assign pend_o     = pend_q;
   assign scl_hold_o = ~pend_q | (floor_cnt != '0);

   // R7: a service event always leaves the pending bit cleared
   p_event_pends_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      svc_event_i |=> !pend_o);
   // R7: a release strobe with no new event sets the pending bit
   p_release_sets_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_o && release_i && !svc_event_i) |=> pend_o);
   // R8: the hold cannot end while the floor counter has more than one clock left
   p_floor_holds_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (scl_hold_o && floor_cnt > CNT_W'(1)) |=> scl_hold_o);
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
   import i2cs_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_s_i,
   input  logic              scl_rise_i,
   input  logic              scl_fall_i,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic [ADDR_W-1:0] own_addr_i,
   input  logic              arb_lost_i,
   input  logic              tx_load_i,
   input  logic [DATA_W-1:0] tx_data_i,
   output logic              sda_low_o,
   output logic              svc_event_o,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              al_o,
   output logic              trx_o,
   output logic              aas_o,
   output logic              ad0_o
);
   localparam int BIT_CW = $clog2(DATA_W + 2);
   localparam logic [BIT_CW-1:0] BYTE_END = BIT_CW'(DATA_W);
   localparam logic [BIT_CW-1:0] ACK_END  = BIT_CW'(DATA_W + 1);

   slv_state_t        state;
   logic [BIT_CW-1:0] bitcnt;
   logic [DATA_W-1:0] rx_sh, tx_sh, rx_data;
   logic              ack_r, aas, ad0, trx, al, al_arm, svc_event;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         bitcnt    <= '0;
         rx_sh     <= '0;
         tx_sh     <= '0;
         rx_data   <= '0;
         ack_r     <= 1'b1;
         aas       <= 1'b0;
         ad0       <= 1'b0;
         trx       <= 1'b0;
         al        <= 1'b0;
         al_arm    <= 1'b0;
         svc_event <= 1'b0;
      end else begin
         svc_event <= 1'b0;
         if (start_i) begin
            state  <= S_ADDR;
            bitcnt <= '0;
            aas    <= 1'b0;
            ad0    <= 1'b0;
            trx    <= 1'b0;
            al     <= 1'b0;
            al_arm <= 1'b0;
         end else if (stop_i) begin
            state  <= S_IDLE;
            bitcnt <= '0;
            aas    <= 1'b0;
            ad0    <= 1'b0;
            trx    <= 1'b0;
            al_arm <= 1'b0;
         end else if (state != S_IDLE) begin
            if (scl_rise_i) begin
               bitcnt <= bitcnt + BIT_CW'(1);
               if ((state == S_ADDR || state == S_RX) && bitcnt < BYTE_END)
                  rx_sh <= {rx_sh[DATA_W-2:0], sda_s_i};
               if (state == S_TX_ACK)
                  ack_r <= sda_s_i;
            end
            if (scl_fall_i) begin
               if (bitcnt == BYTE_END) begin
                  case (state)
                     S_ADDR: begin
                        if (rx_sh[DATA_W-1:1] == own_addr_i) begin
                           aas   <= 1'b1;
                           trx   <= rx_sh[0];
                           state <= S_ADDR_ACK;
                        end else if (rx_sh == '0) begin
                           ad0   <= 1'b1;
                           trx   <= 1'b0;
                           state <= S_ADDR_ACK;
                        end else begin
                           state <= S_SKIP;
                        end
                     end
                     S_RX: begin
                        rx_data <= rx_sh;
                        state   <= S_RX_ACK;
                     end
                     S_TX:    state <= S_TX_ACK;
                     default: ;
                  endcase
               end else if (bitcnt == ACK_END) begin
                  bitcnt <= '0;
                  case (state)
                     S_ADDR_ACK: begin
                        svc_event <= 1'b1;
                        state     <= trx ? S_TX : S_RX;
                     end
                     S_RX_ACK: begin
                        svc_event <= 1'b1;
                        state     <= S_RX;
                     end
                     S_TX_ACK: begin
                        if (!ack_r) begin
                           svc_event <= 1'b1;
                           state     <= S_TX;
                        end else begin
                           trx   <= 1'b0;
                           state <= S_SKIP;
                        end
                     end
                     default: ;
                  endcase
                  if (al_arm) begin
                     svc_event <= 1'b1;
                     al_arm    <= 1'b0;
                  end
               end else if (state == S_TX && bitcnt != '0) begin
                  tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
               end
            end
         end
         if (tx_load_i) tx_sh <= tx_data_i;
         if (arb_lost_i) begin
            al     <= 1'b1;
            al_arm <= 1'b1;
         end
      end
   end

   always_comb begin
      case (state)
         S_ADDR_ACK, S_RX_ACK: sda_low_o = 1'b1;
         S_TX:                 sda_low_o = ~tx_sh[DATA_W-1];
         default:              sda_low_o = 1'b0;
      endcase
   end

   assign svc_event_o = svc_event;
   assign rx_data_o   = rx_data;
   assign al_o        = al;
   assign trx_o       = trx;
   assign aas_o       = aas;
   assign ad0_o       = ad0;

   // R2: a START always opens a fresh address phase
   p_start_addr_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !arb_lost_i) |=> (state == S_ADDR && !aas && !ad0));
   // R3: an unaddressed transfer never touches SDA
   p_skip_silent_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_SKIP) |-> !sda_low_o);
   // R6: data is driven out only in a read-direction transfer
   p_tx_needs_trx_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_TX) |-> trx);
   // R9: a pending arbitration-loss request is always reflected in the flag
   p_arm_flag_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      al_arm |-> al);
   // R10: a STOP leaves the block idle and unaddressed
   p_stop_clears_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && !start_i) |=> (state == S_IDLE && !aas && !ad0));
endmodule

// File: rtl/i2c_slave_stretch.sv
module i2c_slave_stretch #(
   parameter int SYNC_STAGES = 2,
   parameter int LOW_CNT_W   = 8,
   parameter int ADDR_W      = 7,
   parameter int DATA_W      = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 scl_i,
   input  logic                 sda_i,
   output logic                 scl_low_o,
   output logic                 sda_low_o,
   input  logic [ADDR_W-1:0]    own_addr_i,
   input  logic [LOW_CNT_W-1:0] min_low_i,
   input  logic                 dat_wr_i,
   input  logic [DATA_W-1:0]    dat_wdata_i,
   input  logic                 dat_rd_i,
   output logic [DATA_W-1:0]    dat_rdata_o,
   input  logic                 pend_set_i,
   input  logic                 arb_lost_i,
   output logic                 irq_o,
   output logic                 pend_o,
   output logic                 st_al_o,
   output logic                 st_trx_o,
   output logic                 st_aas_o,
   output logic                 st_ad0_o
);
   generate
      if (DATA_W != ADDR_W + 1) begin : g_bad_width
         $error("DATA_W must equal ADDR_W + 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 to 4");
      end
      if (LOW_CNT_W < 1 || LOW_CNT_W > 24) begin : g_bad_cnt
         $error("LOW_CNT_W must be 1 to 24");
      end
   endgenerate

   logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;
   logic svc_event, pend, release_req;

   i2cs_bus_events #(.SYNC_STAGES(SYNC_STAGES)) u_events (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_s_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
      .start_o(start_ev), .stop_o(stop_ev));

   i2cs_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
      .clk(clk), .rst_n(rst_n), .sda_s_i(sda_s),
      .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
      .start_i(start_ev), .stop_i(stop_ev), .own_addr_i(own_addr_i),
      .arb_lost_i(arb_lost_i), .tx_load_i(dat_wr_i), .tx_data_i(dat_wdata_i),
      .sda_low_o(sda_low_o), .svc_event_o(svc_event), .rx_data_o(dat_rdata_o),
      .al_o(st_al_o), .trx_o(st_trx_o), .aas_o(st_aas_o), .ad0_o(st_ad0_o));

   assign release_req = dat_wr_i | dat_rd_i | pend_set_i;

   i2cs_stretch #(.CNT_W(LOW_CNT_W)) u_stretch (
      .clk(clk), .rst_n(rst_n), .svc_event_i(svc_event),
      .release_i(release_req), .min_low_i(min_low_i),
      .pend_o(pend), .scl_hold_o(scl_low_o));

   assign pend_o = pend;
   assign irq_o  = ~pend;

   // R7: the clock line is held for as long as service is pending
   p_hold_pending_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> scl_low_o);
endmodule

// File: tb/tb_i2c_slave_stretch.sv
module tb_i2c_slave_stretch;
   localparam int Q = 12;
   localparam logic [6:0] OWN = 7'h3A;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic scl_low, sda_low;
   logic [7:0] min_low = 8'd4;
   logic dat_wr = 1'b0, dat_rd = 1'b0, pend_set = 1'b0, arb_lost = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic irq, pend, st_al, st_trx, st_aas, st_ad0;
   logic scl_bus, sda_bus;
   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   assign scl_bus = scl_m & ~scl_low;
   assign sda_bus = sda_m & ~sda_low;

   i2c_slave_stretch dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
      .scl_low_o(scl_low), .sda_low_o(sda_low), .own_addr_i(OWN),
      .min_low_i(min_low), .dat_wr_i(dat_wr), .dat_wdata_i(wdata),
      .dat_rd_i(dat_rd), .dat_rdata_o(rdata), .pend_set_i(pend_set),
      .arb_lost_i(arb_lost), .irq_o(irq), .pend_o(pend),
      .st_al_o(st_al), .st_trx_o(st_trx), .st_aas_o(st_aas), .st_ad0_o(st_ad0));

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_high();
      while (!scl_bus) tick(1);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; wait_high(); tick(Q);
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b1; wait_high(); tick(Q);
      sda_m = 1'b1; tick(Q);
   endtask

   task automatic bit_xfer(input logic b, output logic s);
      sda_m = b; tick(Q);
      scl_m = 1'b1; wait_high(); tick(Q);
      s = sda_bus;
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic send_byte(input logic [7:0] v, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) bit_xfer(v[i], s);
      bit_xfer(1'b1, ack);
   endtask

   task automatic recv_byte(input logic nack, output logic [7:0] v);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         bit_xfer(1'b1, s);
         v[i] = s;
      end
      bit_xfer(nack, s);
   endtask

   task automatic pulse_rd();
      dat_rd = 1'b1; tick(1); dat_rd = 1'b0;
   endtask

   task automatic pulse_pend();
      pend_set = 1'b1; tick(1); pend_set = 1'b0;
   endtask

   task automatic pulse_wr(input logic [7:0] v);
      wdata = v; dat_wr = 1'b1; tick(1); dat_wr = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic ack, s;
      logic [7:0] got, v;
      tick(5);
      rst_n = 1'b1;
      tick(3);
      // R1 reset state
      chk("R1 scl_low", scl_low, 0);
      chk("R1 sda_low", sda_low, 0);
      chk("R1 irq", irq, 0);
      chk("R1 pend", pend, 1);
      chk("R1 flags", {st_al, st_trx, st_aas, st_ad0}, 0);

      // R2 R3 R4 R10: sweep every 7-bit address with write direction
      for (int a = 0; a < 128; a++) begin
         bit hit;
         hit = (a == OWN) || (a == 0);
         bus_start();
         send_byte({7'(a), 1'b0}, ack);
         if (a == OWN) begin
            chk("R2 ack own", ack, 0);
            chk("R2 aas", st_aas, 1);
            chk("R2 trx write", st_trx, 0);
            chk("R2 irq", irq, 1);
         end else if (a == 0) begin
            chk("R4 ack gc", ack, 0);
            chk("R4 ad0", st_ad0, 1);
            chk("R4 aas", st_aas, 0);
            chk("R4 irq", irq, 1);
         end else begin
            chk("R3 nack", ack, 1);
            chk("R3 no irq", irq, 0);
            chk("R3 scl free", scl_low, 0);
         end
         if (hit) begin
            chk("R7 stretch", scl_low, 1);
            pulse_rd();
            tick(Q);
            chk("R7 released", scl_low, 0);
         end else if (a[3:0] == 4'h5) begin
            send_byte(8'hA5, ack);
            chk("R3 data ignored", ack, 1);
            chk("R3 data no irq", irq, 0);
         end
         bus_stop();
         chk("R10 stop clears", {st_aas, st_ad0}, 0);
      end

      // R5 R7: receive a run of bytes, alternating release methods
      bus_start();
      send_byte({OWN, 1'b0}, ack);
      chk("R2 ack rx", ack, 0);
      pulse_rd();
      for (int k = 0; k < 16; k++) begin
         v = 8'((k * 37 + 11) % 256);
         send_byte(v, ack);
         chk("R5 ack data", ack, 0);
         chk("R5 irq data", irq, 1);
         chk("R5 rdata", rdata, v);
         if (k == 0) begin
            tick(60);
            chk("R7 still held", scl_low, 1);
            chk("R7 pend low", pend, 0);
         end
         if (k % 2 == 0) pulse_rd();
         else pulse_pend();
         tick(Q);
         chk("R7 irq cleared", irq, 0);
      end
      bus_stop();

      // R8: hold floor outlasts an early release
      min_low = 8'd40;
      bus_start();
      send_byte({OWN, 1'b0}, ack);
      pulse_pend();
      tick(2);
      chk("R8 floor hold", scl_low, 1);
      chk("R8 pend set", pend, 1);
      tick(50);
      chk("R8 floor end", scl_low, 0);
      min_low = 8'd4;
      bus_stop();

      // R6: transmit bytes, master ends with NACK
      bus_start();
      send_byte({OWN, 1'b1}, ack);
      chk("R2 ack read", ack, 0);
      chk("R6 trx", st_trx, 1);
      chk("R6 irq addr", irq, 1);
      for (int k = 0; k < 8; k++) begin
         v = 8'((k * 53 + 7) % 256);
         pulse_wr(v);
         recv_byte(k == 7, got);
         chk("R6 tx byte", got, v);
         if (k < 7) begin
            chk("R6 irq acked", irq, 1);
         end else begin
            chk("R6 irq nack", irq, 0);
            chk("R6 trx nack", st_trx, 0);
            chk("R6 sda free", sda_low, 0);
         end
      end
      bus_stop();

      // R9: arbitration lost on a foreign address
      bus_start();
      for (int i = 7; i >= 0; i--) begin
         bit_xfer(((8'h55 >> i) & 8'h1) != 0, s);
         if (i == 5) begin
            arb_lost = 1'b1; tick(1); arb_lost = 1'b0;
         end
      end
      chk("R9 al set", st_al, 1);
      chk("R9 no early irq", irq, 0);
      bit_xfer(1'b1, ack);
      chk("R9 nack", ack, 1);
      chk("R9 irq at byte end", irq, 1);
      chk("R9 aas", st_aas, 0);
      pulse_pend();
      tick(Q);
      chk("R9 irq cleared", irq, 0);
      bus_start();
      chk("R9 al cleared", st_al, 0);
      bus_stop();

      // R9 with R2: arbitration loss in the same byte as an own-address match
      bus_start();
      for (int i = 7; i >= 0; i--) begin
         bit_xfer((({OWN, 1'b0} >> i) & 8'h1) != 0, s);
         if (i == 6) begin
            arb_lost = 1'b1; tick(1); arb_lost = 1'b0;
         end
      end
      bit_xfer(1'b1, ack);
      chk("R2 ack with al", ack, 0);
      chk("R9 al with match", st_al, 1);
      chk("R2 aas with al", st_aas, 1);
      chk("R7 single irq", irq, 1);
      pulse_pend();
      tick(Q);
      chk("R7 one release", irq, 0);
      chk("R7 scl free", scl_low, 0);
      bus_stop();

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule